// File: doc/BRIEF.md
# Floppy Controller Power-Management Register

This block holds one configuration register that sits next to a floppy disk controller core. Software reaches it through an indexed configuration bus. The register does four things:

- It enables the core's automatic powerdown.
- It drives a software-held reset into the core.
- It places the core in direct powerdown.
- It reports when the core is idle.

Direct powerdown is sticky. Clearing the request bit is not enough to wake the core. A reset must arrive after the bit is cleared, and three sources qualify: the register's own reset bit, the core's digital-output reset (active low) and the core's data-rate reset pulse. The board hard-reset input ends powerdown at once, whatever the request bit holds.

Idle status is high only when three core conditions hold together. The core status must equal 80h, the interrupt line must be low, and the head-unload timer must have expired. These conditions pass through one register stage before they are read back.

Top module: `fdc_pm_reg`

## Requirements
- R1: After reset the register at index 11h reads 00h, and core_rst_o, pdn_o and auto_pdn_en_o are all 0.
- R2: Bit 3 is the auto-powerdown enable. It reads back as written and drives auto_pdn_en_o.
- R3: Bit 2 is the core reset. It reads back as written, and core_rst_o is 1 while bit 2 is 1 or board_rst_i is 1.
- R4: Bit 1 reads 1 exactly when, on the previous clock edge, core_status_i was 80h, core_irq_i was 0 and hut_expired_i was 1.
- R5: Bits 7:4 always read 0. Writes to bits 7:4 and to bit 1 have no effect.
- R6: Bit 0 reads back as written. Writing 1 to bit 0 sets pdn_o on the clock edge of the write.
- R7: Once pdn_o is set, it stays 1 while bit 0 is 1, even during a qualifying reset. It also stays 1 after bit 0 is cleared until a qualifying reset arrives.
- R8: There are three qualifying resets: bit 2 equal to 1, digout_rst_n_i equal to 0, and rate_rst_i equal to 1. Any one of them, present on a clock edge while bit 0 is 0, clears pdn_o on that edge.
- R9: board_rst_i equal to 1 clears pdn_o on the next edge whatever bit 0 holds, and it overrides a write that sets bit 0 in the same cycle.
- R10: Reads at any index other than 11h return 0, and writes at other indexes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_idx_i | input | 8 | Configuration index |
| cfg_we_i | input | 1 | Write enable |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for the current index |
| core_status_i | input | 8 | Core main status value |
| core_irq_i | input | 1 | Core interrupt line |
| hut_expired_i | input | 1 | Head-unload timer expired |
| digout_rst_n_i | input | 1 | Core digital-output reset, active low |
| rate_rst_i | input | 1 | Core data-rate reset pulse, active high |
| board_rst_i | input | 1 | Board hard reset, active high |
| core_rst_o | output | 1 | Reset to the core |
| pdn_o | output | 1 | Powerdown request to the core |
| auto_pdn_en_o | output | 1 | Auto-powerdown enable to the core |

## Verification
The bench sweeps all 1024 combinations of status, interrupt and timer. A decoder that accepts a partial status match, or ignores the interrupt, would show idle in the wrong cases. It also writes all 256 data values and compares the readback field by field, which catches reserved bits that leak through or a bit 1 that can be written.

The powerdown tests look at two cases in particular. The first is a reset that arrives while bit 0 is still 1; a design that does not qualify the reset would wake the core early. The second is clearing bit 0 with no reset; a design that follows the bit directly would drop pdn_o there.

Further tests cover each of the three wake sources alone and a write of reset and clear together, which takes two edges. They also cover a board reset that coincides with a write setting bit 0, and a write at a different index.

// File: rtl/fdc_pm_pkg.sv
package fdc_pm_pkg;
  localparam int unsigned BIT_PDN  = 0;
  localparam int unsigned BIT_IDLE = 1;
  localparam int unsigned BIT_RST  = 2;
  localparam int unsigned BIT_AUTO = 3;
  localparam int unsigned USED_W   = 4;

  typedef struct packed {
    logic auto_en;
    logic soft_rst;
    logic pdn_req;
  } pm_fields_t;
endpackage

// File: rtl/fdc_pm_cfg.sv
module fdc_pm_cfg
  import fdc_pm_pkg::*;
#(
  parameter int unsigned   IDX_W   = 8,
  parameter int unsigned   DATA_W  = 8,
  parameter logic [IDX_W-1:0] REG_IDX = 'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              wr_o,
  output pm_fields_t        fields_o
);
  assign hit_o = (idx_i == REG_IDX);
  assign wr_o  = hit_o && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_o <= '0;
    end else if (wr_o) begin
      fields_o.auto_en  <= wdata_i[BIT_AUTO];
      fields_o.soft_rst <= wdata_i[BIT_RST];
      fields_o.pdn_req  <= wdata_i[BIT_PDN];
    end
  end
endmodule

// File: rtl/fdc_pm_idle.sv
module fdc_pm_idle #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_CODE = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic              irq_i,
  input  logic              hut_i,
  output logic              idle_o
);
  logic idle_d;
  assign idle_d = (status_i == IDLE_CODE) && !irq_i && hut_i;

  // single stage so readback never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_o <= 1'b0;
    else         idle_o <= idle_d;
  end
endmodule

// File: rtl/fdc_pm_pdn.sv
module fdc_pm_pdn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic pdn_req_i,
  input  logic soft_rst_i,
  input  logic digout_rst_n_i,
  input  logic rate_rst_i,
  input  logic board_rst_i,
  output logic pdn_o
);
  logic wake;
  assign wake = (soft_rst_i || !digout_rst_n_i || rate_rst_i) && !pdn_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pdn_o <= 1'b0;
    else if (board_rst_i) pdn_o <= 1'b0;
    else if (set_i)       pdn_o <= 1'b1;
    else if (wake)        pdn_o <= 1'b0;
  end
endmodule

// File: rtl/fdc_pm_reg.sv
module fdc_pm_reg
  import fdc_pm_pkg::*;
#(
  parameter int unsigned      IDX_W     = 8,
  parameter int unsigned      DATA_W    = 8,
  parameter logic [IDX_W-1:0] REG_IDX   = 'h11,
  parameter logic [7:0]       IDLE_CODE = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [7:0]        core_status_i,
  input  logic              core_irq_i,
  input  logic              hut_expired_i,
  input  logic              digout_rst_n_i,
  input  logic              rate_rst_i,
  input  logic              board_rst_i,
  output logic              core_rst_o,
  output logic              pdn_o,
  output logic              auto_pdn_en_o
);
  pm_fields_t fields;
  logic hit, wr, idle_q, pdn_req;

  fdc_pm_cfg #(.IDX_W(IDX_W), .DATA_W(DATA_W), .REG_IDX(REG_IDX)) u_cfg (
    .clk_i, .rst_ni, .idx_i(cfg_idx_i), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .hit_o(hit), .wr_o(wr), .fields_o(fields)
  );

  fdc_pm_idle #(.DATA_W(8), .IDLE_CODE(IDLE_CODE)) u_idle (
    .clk_i, .rst_ni, .status_i(core_status_i), .irq_i(core_irq_i),
    .hut_i(hut_expired_i), .idle_o(idle_q)
  );

  assign pdn_req = fields.pdn_req;

  fdc_pm_pdn u_pdn (
    .clk_i, .rst_ni,
    .set_i(wr && cfg_wdata_i[BIT_PDN]),
    .pdn_req_i(pdn_req),
    .soft_rst_i(fields.soft_rst),
    .digout_rst_n_i, .rate_rst_i, .board_rst_i,
    .pdn_o
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (hit) begin
      cfg_rdata_o[BIT_AUTO] = fields.auto_en;
      cfg_rdata_o[BIT_RST]  = fields.soft_rst;
      cfg_rdata_o[BIT_IDLE] = idle_q;
      cfg_rdata_o[BIT_PDN]  = fields.pdn_req;
    end
  end

  assign core_rst_o    = fields.soft_rst || board_rst_i;
  assign auto_pdn_en_o = fields.auto_en;
endmodule

// File: rtl/fdc_pm_reg_chk.sv
module fdc_pm_reg_chk #(
  parameter int unsigned      IDX_W     = 8,
  parameter int unsigned      DATA_W    = 8,
  parameter logic [IDX_W-1:0] REG_IDX   = 'h11,
  parameter logic [7:0]       IDLE_CODE = 8'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic              cfg_we_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic [7:0]        core_status_i,
  input logic              core_irq_i,
  input logic              hut_expired_i,
  input logic              board_rst_i,
  input logic              core_rst_o,
  input logic              pdn_o,
  input logic              pdn_req,
  input logic              idle_q
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  logic cond;
  assign cond = (core_status_i == IDLE_CODE) && !core_irq_i && hut_expired_i;

  logic wr_hit;
  assign wr_hit = cfg_we_i && (cfg_idx_i == REG_IDX);

  assert_rsvd_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[DATA_W-1:4] == '0);

  assert_idle_stage_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (idle_q == $past(cond)));

  assert_soft_rst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && cfg_wdata_i[2] |=> core_rst_o);

  assert_pdn_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && cfg_wdata_i[0] && !board_rst_i |=> pdn_o);

  assert_pdn_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o && pdn_req && !board_rst_i |=> pdn_o);

  assert_board_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_i |=> !pdn_o);

  assert_other_idx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx_i != REG_IDX) |-> (cfg_rdata_o == '0));
endmodule

bind fdc_pm_reg fdc_pm_reg_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_IDX(REG_IDX), .IDLE_CODE(IDLE_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_idx_i(cfg_idx_i), .cfg_we_i(cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .core_status_i(core_status_i), .core_irq_i(core_irq_i),
  .hut_expired_i(hut_expired_i), .board_rst_i(board_rst_i),
  .core_rst_o(core_rst_o), .pdn_o(pdn_o), .pdn_req(pdn_req), .idle_q(idle_q)
);

// File: tb/fdc_pm_reg_test.sv
module fdc_pm_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] idx = 8'h11;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] status = '0;
  logic       irq = 1'b0, hut = 1'b0;
  logic       dor_n = 1'b1, rate = 1'b0, board = 1'b0;
  logic       core_rst, pdn, auto_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fdc_pm_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_idx_i(idx), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .core_status_i(status),
    .core_irq_i(irq), .hut_expired_i(hut), .digout_rst_n_i(dor_n),
    .rate_rst_i(rate), .board_rst_i(board), .core_rst_o(core_rst),
    .pdn_o(pdn), .auto_pdn_en_o(auto_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write applied at the edge between two negedges
  task automatic wr(input logic [7:0] d, input logic [7:0] at = 8'h11);
    @(negedge clk); idx = at; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; idx = 8'h11;
    #2;
  endtask

  task automatic step;
    @(negedge clk); #2;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outs", {5'b0, core_rst, pdn, auto_en}, 8'h00);

    // R4 exhaustive idle sweep
    for (int s = 0; s < 256; s++)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        status = s[7:0]; irq = k[0]; hut = k[1];
        @(negedge clk); #2;
        chk("R4 idle", {7'b0, rdata[1]}, {7'b0, (s == 8'h80) && !k[0] && k[1]});
      end
    status = '0; irq = 0; hut = 0;
    step();

    // R2 R3 R5 R6 full write sweep
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0]);
      chk("R5 R6 readback", rdata, {4'b0, d[3], d[2], 1'b0, d[0]});
      chk("R2 auto_en", {7'b0, auto_en}, {7'b0, d[3]});
      chk("R3 core_rst", {7'b0, core_rst}, {7'b0, d[2]});
    end
    wr(8'h00);
    @(negedge clk); board = 1'b1; #2;
    chk("R3 board core_rst", {7'b0, core_rst}, 8'h01);
    @(negedge clk); board = 1'b0; #2;
    chk("R9 board clr", {7'b0, pdn}, 8'h00);

    // R6 set, R7 hold under reset while bit0=1
    wr(8'h01);
    chk("R6 pdn set", {7'b0, pdn}, 8'h01);
    @(negedge clk); rate = 1'b1; dor_n = 1'b0;
    @(negedge clk); rate = 1'b0; dor_n = 1'b1; #2;
    chk("R7 reset ignored while req", {7'b0, pdn}, 8'h01);
    wr(8'h00);
    step();
    chk("R7 clear alone keeps pdn", {7'b0, pdn}, 8'h01);
    // R8 rate reset
    @(negedge clk); rate = 1'b1;
    @(negedge clk); rate = 1'b0; #2;
    chk("R8 rate wake", {7'b0, pdn}, 8'h00);
    // R8 digout reset
    wr(8'h01); wr(8'h00);
    chk("R8 pre digout", {7'b0, pdn}, 8'h01);
    @(negedge clk); dor_n = 1'b0;
    @(negedge clk); dor_n = 1'b1; #2;
    chk("R8 digout wake", {7'b0, pdn}, 8'h00);
    // R8 soft reset bit written with clear: two edges
    wr(8'h01); wr(8'h04);
    chk("R8 soft first edge", {7'b0, pdn}, 8'h01);
    step();
    chk("R8 soft second edge", {7'b0, pdn}, 8'h00);
    wr(8'h00);
    // R7 req and reset together hold
    wr(8'h05); step(); step();
    chk("R7 set with rst bit", {7'b0, pdn}, 8'h01);
    wr(8'h00); step();
    chk("R7 no wake after rst dropped", {7'b0, pdn}, 8'h01);
    // R9 board with bit0=1, and overriding a set
    wr(8'h01);
    @(negedge clk); board = 1'b1;
    @(negedge clk); board = 1'b0; #2;
    chk("R9 board clr req=1", {7'b0, pdn}, 8'h00);
    chk("R9 req bit kept", {7'b0, rdata[0]}, 8'h01);
    wr(8'h00);
    @(negedge clk); idx = 8'h11; we = 1'b1; wdata = 8'h01; board = 1'b1;
    @(negedge clk); we = 1'b0; board = 1'b0; #2;
    chk("R9 board beats set", {7'b0, pdn}, 8'h00);

    // R10 other index
    wr(8'h00);
    wr(8'h0F, 8'h12);
    chk("R10 no write", rdata, 8'h00);
    chk("R10 no pdn", {5'b0, core_rst, pdn, auto_en}, 8'h00);
    @(negedge clk); idx = 8'h12; wr(8'h08); idx = 8'h12; #2;
    chk("R10 read other idx", rdata, 8'h00);
    idx = 8'h11; #2;
    chk("R10 own idx", rdata, 8'h08);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule